// File: doc/BRIEF.md
# Interrupt and Stack Sequencer

This block is the control slice of an 8-bit processor that owns the program counter, the stack pointer and the processor status byte. It runs every sequence that touches the stack or a vector. These are the power-up vector fetch, the entries for the non-maskable and maskable hardware interrupts, the software break, subroutine call and return, return from interrupt, and pushing the status byte. Instruction decode sits outside the block and asks for each sequence with a one-cycle request pulse. That same logic raises `last_cycle` when the instruction in flight has one cycle left, which is the only point where pending interrupts are considered.

All traffic goes through a byte-wide memory port that makes one access per clock. Read data returns in the cycle after the address is driven. The stack occupies one fixed page, and the stack pointer supplies the low address byte. Status bit 2 is the interrupt-disable flag. Bit 4 is the break marker, which exists only in pushed copies. Bit 5 is the unused bit, which reads as one.

Top module: `irq_stack_seq`

## Requirements
- R1: Reset holds the block busy for 7 cycles after `rst_n` rises. It reads the low PC byte from 0xFFFC and the high byte from 0xFFFD. It leaves SP = 0xFD and status = 0x34.
- R2: A push writes to address 0x0100 + SP and then decrements SP. A pop first increments SP and then reads from 0x0100 + SP.
- R3: Interrupts are accepted only in an idle cycle with `last_cycle` high. A latched NMI takes priority over IRQ, and an interrupt takes priority over any instruction request in the same cycle.
- R4: IRQ is a level input. It is ignored while status bit 2 is set.
- R5: Hardware interrupt entry lasts 6 cycles. It pushes PC high, then PC low, then the status byte with bit 4 cleared. NMI takes its PC from 0xFFFA (low) and 0xFFFB (high) and leaves status bit 2 unchanged.
- R6: IRQ entry takes its PC from 0xFFFE/0xFFFF and sets status bit 2.
- R7: Break first adds one to the PC. It then pushes the PC high and low bytes and the status byte with bits 4 and 5 set. It loads the PC from 0xFFFE/0xFFFF, sets status bit 2, and lasts 6 cycles.
- R8: A call pushes (PC - 1), high byte first, and then loads the PC from `jsr_target`. It lasts 2 cycles.
- R9: Return from subroutine pops the low byte and then the high byte, and sets the PC to that value plus one. It lasts 3 cycles.
- R10: Return from interrupt pops the status byte (bits 4 and 5 forced to one), then the PC low byte, then the PC high byte. It lasts 4 cycles.
- R11: Status push writes the status byte with bits 4 and 5 set. It lasts 1 cycle.
- R12: A rising edge on `nmi` is latched even while a sequence runs. The latch holds until its entry starts and then clears, so one edge gives exactly one entry.
- R13: While idle, `stat_we` loads `stat_wdata` into the status byte at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the vector fetch on release |
| nmi | input | 1 | Non-maskable request, rising-edge sensitive |
| irq | input | 1 | Maskable request, level sensitive |
| last_cycle | input | 1 | Current instruction has one cycle left |
| op_brk | input | 1 | Request break sequence |
| op_jsr | input | 1 | Request subroutine call |
| op_rts | input | 1 | Request subroutine return |
| op_rti | input | 1 | Request interrupt return |
| op_php | input | 1 | Request status push |
| jsr_target | input | 16 | Call destination address |
| stat_we | input | 1 | Status byte write strobe (idle only) |
| stat_wdata | input | 8 | Status byte write value |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, valid one cycle after address |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| status | output | 8 | Processor status byte |
| busy | output | 1 | A sequence is running |

## Verification
A request sampled at a clock edge makes `busy` high from that edge onward. The sequence then lasts a fixed number of cycles: 1 for status push, 2 for call, 3 for return from subroutine, 4 for return from interrupt, 6 for interrupt or break entry, and 7 for reset. The PC, SP and status results all appear at the edge that drops `busy`. The bench samples on falling edges and counts the falling edges at which `busy` is high, so every sequence length is checked exactly. Final register values and the stack bytes held in the bench's memory model are read at the first falling edge with `busy` low. An NMI edge is driven one cycle before `last_cycle`, because the latch needs one edge before it becomes visible to arbitration.

// File: rtl/isq_pkg.sv
package isq_pkg;

   typedef enum logic [3:0] {
      OP_NONE,
      OP_RESET,
      OP_NMI,
      OP_IRQ,
      OP_BRK,
      OP_JSR,
      OP_RTS,
      OP_RTI,
      OP_PHP
   } isq_op_e;

endpackage

// File: rtl/isq_nmi_latch.sv
module isq_nmi_latch #(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_in,
   input  logic clear,
   output logic pend
);

   logic set_req;

   generate
      if (EDGE_MODE) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= nmi_in;
         end
         assign set_req = nmi_in & ~prev_q;
      end else begin : g_level
         assign set_req = nmi_in;
      end
   endgenerate

   // a new request wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend <= 1'b0;
      else if (set_req) pend <= 1'b1;
      else if (clear)   pend <= 1'b0;
   end

endmodule

// File: rtl/isq_stack_ptr.sv
module isq_stack_ptr #(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] RESET_VAL = 8'hFD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   output logic [DATA_W-1:0] sp
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sp <= RESET_VAL;
      else if (push) sp <= sp - 1'b1;
      else if (pop)  sp <= sp + 1'b1;
   end

endmodule

// File: rtl/isq_arbiter.sv
module isq_arbiter
   import isq_pkg::*;
(
   input  logic    idle,
   input  logic    last_cycle,
   input  logic    nmi_pend,
   input  logic    irq,
   input  logic    idis,
   input  logic    req_brk,
   input  logic    req_jsr,
   input  logic    req_rts,
   input  logic    req_rti,
   input  logic    req_php,
   output isq_op_e pick
);

   always_comb begin
      pick = OP_NONE;
      if (idle) begin
         if (last_cycle && nmi_pend)              pick = OP_NMI;
         else if (last_cycle && irq && !idis)     pick = OP_IRQ;
         else if (req_brk)                        pick = OP_BRK;
         else if (req_jsr)                        pick = OP_JSR;
         else if (req_rts)                        pick = OP_RTS;
         else if (req_rti)                        pick = OP_RTI;
         else if (req_php)                        pick = OP_PHP;
      end
   end

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
   import isq_pkg::*;
#(
   parameter int                DATA_W       = 8,
   parameter int                ADDR_W       = 16,
   parameter logic [DATA_W-1:0] STACK_PAGE   = 8'h01,
   parameter logic [DATA_W-1:0] RESET_SP     = 8'hFD,
   parameter logic [DATA_W-1:0] RESET_STATUS = 8'h34,
   parameter logic [ADDR_W-1:0] VEC_NMI      = 16'hFFFA,
   parameter logic [ADDR_W-1:0] VEC_RST      = 16'hFFFC,
   parameter logic [ADDR_W-1:0] VEC_IRQ      = 16'hFFFE,
   parameter int                RST_LEAD     = 4,
   parameter int                IDIS_BIT     = 2,
   parameter int                BRK_BIT      = 4,
   parameter int                ONE_BIT      = 5,
   parameter bit                NMI_EDGE     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi,
   input  logic              irq,
   input  logic              last_cycle,
   input  logic              op_brk,
   input  logic              op_jsr,
   input  logic              op_rts,
   input  logic              op_rti,
   input  logic              op_php,
   input  logic [ADDR_W-1:0] jsr_target,
   input  logic              stat_we,
   input  logic [DATA_W-1:0] stat_wdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] pc,
   output logic [DATA_W-1:0] sp,
   output logic [DATA_W-1:0] status,
   output logic              busy
);

   localparam int STEP_N = (RST_LEAD + 3 > 6) ? RST_LEAD + 3 : 6;
   localparam int STEP_W = $clog2(STEP_N);
   localparam logic [STEP_W-1:0] S0    = STEP_W'(0);
   localparam logic [STEP_W-1:0] S1    = STEP_W'(1);
   localparam logic [STEP_W-1:0] S2    = STEP_W'(2);
   localparam logic [STEP_W-1:0] S3    = STEP_W'(3);
   localparam logic [STEP_W-1:0] S4    = STEP_W'(4);
   localparam logic [STEP_W-1:0] S5    = STEP_W'(5);
   localparam logic [STEP_W-1:0] R_LO  = STEP_W'(RST_LEAD);
   localparam logic [STEP_W-1:0] R_HI  = STEP_W'(RST_LEAD + 1);
   localparam logic [STEP_W-1:0] R_END = STEP_W'(RST_LEAD + 2);
   localparam logic [DATA_W-1:0] IDIS_M = DATA_W'(1) << IDIS_BIT;
   localparam logic [DATA_W-1:0] BRK_M  = DATA_W'(1) << BRK_BIT;
   localparam logic [DATA_W-1:0] ONE_M  = DATA_W'(1) << ONE_BIT;

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_addr
         $error("ADDR_W must be twice DATA_W");
      end
      if (DATA_W < 6 || IDIS_BIT >= DATA_W || BRK_BIT >= DATA_W || ONE_BIT >= DATA_W) begin : g_bad_bits
         $error("status bit positions exceed DATA_W");
      end
      if (RST_LEAD < 0) begin : g_bad_lead
         $error("RST_LEAD must be non-negative");
      end
   endgenerate

   isq_op_e             op, pick;
   logic [STEP_W-1:0]   step;
   logic [DATA_W-1:0]   lo_buf;
   logic                push, pop, finish, nmi_pend, nmi_clr;
   logic [ADDR_W-1:0]   pc_m1, vec_base;
   logic [DATA_W-1:0]   sp_up, stat_hw, stat_sw;

   assign busy     = (op != OP_NONE);
   assign pc_m1    = pc - 1'b1;
   assign sp_up    = sp + 1'b1;
   assign vec_base = (op == OP_NMI) ? VEC_NMI : VEC_IRQ;
   assign stat_hw  = status & ~BRK_M;
   assign stat_sw  = status | BRK_M | ONE_M;
   assign nmi_clr  = (pick == OP_NMI);

   isq_nmi_latch #(.EDGE_MODE(NMI_EDGE)) u_nmi (
      .clk    (clk),
      .rst_n  (rst_n),
      .nmi_in (nmi),
      .clear  (nmi_clr),
      .pend   (nmi_pend)
   );

   isq_stack_ptr #(.DATA_W(DATA_W), .RESET_VAL(RESET_SP)) u_sp (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (pop),
      .sp    (sp)
   );

   isq_arbiter u_arb (
      .idle       (!busy),
      .last_cycle (last_cycle),
      .nmi_pend   (nmi_pend),
      .irq        (irq),
      .idis       (status[IDIS_BIT]),
      .req_brk    (op_brk),
      .req_jsr    (op_jsr),
      .req_rts    (op_rts),
      .req_rti    (op_rti),
      .req_php    (op_php),
      .pick       (pick)
   );

   // memory port and stack pointer control for the current step
   always_comb begin
      mem_addr  = pc;
      mem_wdata = '0;
      mem_we    = 1'b0;
      push      = 1'b0;
      pop       = 1'b0;
      finish    = 1'b0;
      unique case (op)
         OP_RESET: begin
            if (step == R_LO)  mem_addr = VEC_RST;
            if (step == R_HI)  mem_addr = VEC_RST + 1'b1;
            if (step == R_END) finish   = 1'b1;
         end
         OP_NMI, OP_IRQ, OP_BRK: begin
            case (step)
               S0: begin
                  mem_we = 1'b1; push = 1'b1; mem_addr = {STACK_PAGE, sp};
                  mem_wdata = pc[ADDR_W-1:DATA_W];
               end
               S1: begin
                  mem_we = 1'b1; push = 1'b1; mem_addr = {STACK_PAGE, sp};
                  mem_wdata = pc[DATA_W-1:0];
               end
               S2: begin
                  mem_we = 1'b1; push = 1'b1; mem_addr = {STACK_PAGE, sp};
                  mem_wdata = (op == OP_BRK) ? stat_sw : stat_hw;
               end
               S3:      mem_addr = vec_base;
               S4:      mem_addr = vec_base + 1'b1;
               default: finish   = 1'b1;
            endcase
         end
         OP_JSR: begin
            mem_we = 1'b1; push = 1'b1; mem_addr = {STACK_PAGE, sp};
            if (step == S0) mem_wdata = pc_m1[ADDR_W-1:DATA_W];
            else begin
               mem_wdata = pc_m1[DATA_W-1:0];
               finish    = 1'b1;
            end
         end
         OP_RTS: begin
            if (step == S2) finish = 1'b1;
            else begin
               pop = 1'b1; mem_addr = {STACK_PAGE, sp_up};
            end
         end
         OP_RTI: begin
            if (step == S3) finish = 1'b1;
            else begin
               pop = 1'b1; mem_addr = {STACK_PAGE, sp_up};
            end
         end
         OP_PHP: begin
            mem_we = 1'b1; push = 1'b1; finish = 1'b1;
            mem_addr = {STACK_PAGE, sp}; mem_wdata = stat_sw;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op     <= OP_RESET;
         step   <= '0;
         pc     <= '0;
         lo_buf <= '0;
         status <= RESET_STATUS;
      end else if (op == OP_NONE) begin
         if (stat_we) status <= stat_wdata;
         if (pick != OP_NONE) begin
            op   <= pick;
            step <= '0;
            if (pick == OP_BRK) pc <= pc + 1'b1;
         end
      end else begin
         step <= step + 1'b1;
         case (op)
            OP_RESET: begin
               if (step == R_HI)  lo_buf <= mem_rdata;
               if (step == R_END) pc     <= {mem_rdata, lo_buf};
            end
            OP_NMI, OP_IRQ, OP_BRK: begin
               if (step == S2 && op != OP_NMI) status <= status | IDIS_M;
               if (step == S4) lo_buf <= mem_rdata;
               if (step == S5) pc     <= {mem_rdata, lo_buf};
            end
            OP_JSR: if (step == S1) pc <= jsr_target;
            OP_RTS: begin
               if (step == S1) lo_buf <= mem_rdata;
               if (step == S2) pc     <= {mem_rdata, lo_buf} + 1'b1;
            end
            OP_RTI: begin
               if (step == S1) status <= mem_rdata | BRK_M | ONE_M;
               if (step == S2) lo_buf <= mem_rdata;
               if (step == S3) pc     <= {mem_rdata, lo_buf};
            end
            default: ;
         endcase
         if (finish) begin
            op   <= OP_NONE;
            step <= '0;
         end
      end
   end

endmodule

// File: rtl/isq_checker.sv
module isq_checker
   import isq_pkg::*;
#(
   parameter int                DATA_W     = 8,
   parameter int                ADDR_W     = 16,
   parameter int                STEP_W     = 3,
   parameter int                IDIS_BIT   = 2,
   parameter int                BRK_BIT    = 4,
   parameter int                ONE_BIT    = 5,
   parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01
) (
   input logic              clk,
   input logic              rst_n,
   input isq_op_e           op,
   input logic [STEP_W-1:0] step,
   input logic              busy,
   input logic              last_cycle,
   input logic              nmi_pend,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] sp,
   input logic [DATA_W-1:0] status
);

   // R2
   push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_addr == {STACK_PAGE, sp});

   // R2
   push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> sp == $past(sp) - 1'b1);

   // R3
   nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && last_cycle && nmi_pend) |=> op == OP_NMI);

   // R4
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_IRQ && step == '0) |-> !$past(status[IDIS_BIT]));

   // R5
   hw_brk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && (op == OP_NMI || op == OP_IRQ) && step == STEP_W'(2)) |-> !mem_wdata[BRK_BIT]);

   // R11
   sw_push_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && (op == OP_PHP || (op == OP_BRK && step == STEP_W'(2))))
         |-> (mem_wdata[BRK_BIT] && mem_wdata[ONE_BIT]));

endmodule

bind irq_stack_seq isq_checker #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STEP_W(STEP_W),
   .IDIS_BIT(IDIS_BIT), .BRK_BIT(BRK_BIT), .ONE_BIT(ONE_BIT),
   .STACK_PAGE(STACK_PAGE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .op(op), .step(step), .busy(busy),
   .last_cycle(last_cycle), .nmi_pend(nmi_pend), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sp(sp), .status(status)
);

// File: tb/irq_stack_seq_test.sv
`timescale 1ns/1ps
module irq_stack_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi = 0, irq = 0, last_cycle = 0;
   logic        op_brk = 0, op_jsr = 0, op_rts = 0, op_rti = 0, op_php = 0;
   logic [15:0] jsr_target = '0;
   logic        stat_we = 0;
   logic [7:0]  stat_wdata = '0;
   logic [15:0] mem_addr, pc;
   logic [7:0]  mem_wdata, mem_rdata, sp, status;
   logic        mem_we, busy;

   int nchk = 0, nerr = 0;

   always #2 clk = ~clk;

   irq_stack_seq uut (
      .clk(clk), .rst_n(rst_n), .nmi(nmi), .irq(irq), .last_cycle(last_cycle),
      .op_brk(op_brk), .op_jsr(op_jsr), .op_rts(op_rts), .op_rti(op_rti), .op_php(op_php),
      .jsr_target(jsr_target), .stat_we(stat_we), .stat_wdata(stat_wdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
      .pc(pc), .sp(sp), .status(status), .busy(busy)
   );

   // memory model: stack page plus fixed vectors, one cycle read latency
   logic [7:0] stk [256];

   function automatic logic [7:0] rd_model(input logic [15:0] a);
      case (a)
         16'hFFFA: return 8'h34;
         16'hFFFB: return 8'h12;
         16'hFFFC: return 8'h00;
         16'hFFFD: return 8'hC0;
         16'hFFFE: return 8'h78;
         16'hFFFF: return 8'h56;
         default:  return (a[15:8] == 8'h01) ? stk[a[7:0]] : 8'hEA;
      endcase
   endfunction

   always @(posedge clk) begin
      if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= rd_model(mem_addr);
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_seq(output int len);
      len = 0;
      while (busy && len < 50) begin
         len++;
         @(negedge clk);
      end
   endtask

   // kind: 0 break, 1 call, 2 return, 3 interrupt return, 4 status push, 5 last_cycle
   task automatic go(input int kind, output int len);
      case (kind)
         0: op_brk = 1;
         1: op_jsr = 1;
         2: op_rts = 1;
         3: op_rti = 1;
         4: op_php = 1;
         default: last_cycle = 1;
      endcase
      @(negedge clk);
      {op_brk, op_jsr, op_rts, op_rti, op_php, last_cycle} = '0;
      run_seq(len);
   endtask

   task automatic write_status(input logic [7:0] v);
      stat_we = 1; stat_wdata = v;
      @(negedge clk);
      stat_we = 0;
      @(negedge clk);
   endtask

   typedef struct packed {
      logic [15:0] tgt;
      logic [7:0]  exp_sp;
      logic [7:0]  ret_hi;
      logic [7:0]  ret_lo;
   } call_vec_t;

   localparam call_vec_t CALLS [3] = '{
      '{tgt: 16'h2000, exp_sp: 8'hFB, ret_hi: 8'hBF, ret_lo: 8'hFF},
      '{tgt: 16'h3456, exp_sp: 8'hF9, ret_hi: 8'h1F, ret_lo: 8'hFF},
      '{tgt: 16'h80FF, exp_sp: 8'hF7, ret_hi: 8'h34, ret_lo: 8'h55}
   };

   initial begin
      #400000;
      nerr++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      int len;
      for (int i = 0; i < 256; i++) stk[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "sp in reset", sp, 8'hFD);
      chk("R1", "status in reset", status, 8'h34);
      rst_n = 1;
      run_seq(len);
      chk("R1", "reset length", len, 7);
      chk("R1", "reset pc", pc, 16'hC000);
      chk("R1", "reset sp", sp, 8'hFD);

      // R8 R2 call table
      for (int i = 0; i < 3; i++) begin
         logic [7:0] sp0;
         sp0 = sp;
         jsr_target = CALLS[i].tgt;
         go(1, len);
         chk("R8", "call length", len, 2);
         chk("R8", "call pc", pc, CALLS[i].tgt);
         chk("R2", "call sp", sp, CALLS[i].exp_sp);
         chk("R8", "pushed high", stk[sp0], CALLS[i].ret_hi);
         chk("R8", "pushed low", stk[sp0 - 8'd1], CALLS[i].ret_lo);
      end
      // R9 unwind
      for (int i = 2; i >= 0; i--) begin
         go(2, len);
         chk("R9", "return length", len, 3);
         chk("R9", "return pc", pc, {CALLS[i].ret_hi, CALLS[i].ret_lo} + 16'd1);
         chk("R2", "return sp", sp, CALLS[i].exp_sp + 8'd2);
      end

      // R13 status write, R11 status push
      write_status(8'h01);
      chk("R13", "status write", status, 8'h01);
      go(4, len);
      chk("R11", "push length", len, 1);
      chk("R11", "pushed status", stk[8'hFD], 8'h31);
      chk("R2", "push sp", sp, 8'hFC);

      // R3 R5 NMI beats IRQ
      write_status(8'h31);
      nmi = 1;
      @(negedge clk);
      irq = 1; last_cycle = 1;
      @(negedge clk);
      last_cycle = 0;
      run_seq(len);
      nmi = 0; irq = 0;
      chk("R5", "nmi length", len, 6);
      chk("R3", "nmi vector pc", pc, 16'h1234);
      chk("R5", "nmi pushed high", stk[8'hFC], 8'hC0);
      chk("R5", "nmi pushed low", stk[8'hFB], 8'h00);
      chk("R5", "nmi pushed status", stk[8'hFA], 8'h21);
      chk("R5", "nmi keeps flag", status, 8'h31);
      chk("R2", "nmi sp", sp, 8'hF9);

      // R10 interrupt return
      go(3, len);
      chk("R10", "rti length", len, 4);
      chk("R10", "rti pc", pc, 16'hC000);
      chk("R10", "rti status", status, 8'h31);
      chk("R2", "rti sp", sp, 8'hFC);

      // R3 irq without last_cycle is not taken
      irq = 1;
      @(negedge clk);
      chk("R3", "irq waits for last_cycle", busy, 1'b0);
      // R6 IRQ entry
      go(5, len);
      irq = 0;
      chk("R6", "irq length", len, 6);
      chk("R6", "irq vector pc", pc, 16'h5678);
      chk("R6", "irq sets flag", status, 8'h35);
      chk("R5", "irq pushed status", stk[8'hFA], 8'h21);

      // R4 masked
      irq = 1;
      go(5, len);
      irq = 0;
      chk("R4", "masked irq busy", len, 0);
      chk("R4", "masked irq pc", pc, 16'h5678);

      // R7 break
      write_status(8'h00);
      go(0, len);
      chk("R7", "brk length", len, 6);
      chk("R7", "brk pc", pc, 16'h5678);
      chk("R7", "brk pushed high", stk[8'hF9], 8'h56);
      chk("R7", "brk pushed low", stk[8'hF8], 8'h79);
      chk("R7", "brk pushed status", stk[8'hF7], 8'h30);
      chk("R7", "brk sets flag", status, 8'h04);
      chk("R7", "brk sp", sp, 8'hF6);

      // R12 NMI edge during a running sequence is held
      op_rti = 1;
      @(negedge clk);
      op_rti = 0; nmi = 1;
      run_seq(len);
      nmi = 0;
      chk("R12", "rti undisturbed length", len, 4);
      chk("R10", "rti after brk pc", pc, 16'h5679);
      @(negedge clk);
      chk("R3", "held nmi waits", busy, 1'b0);
      go(5, len);
      chk("R12", "held nmi length", len, 6);
      chk("R12", "held nmi pc", pc, 16'h1234);
      chk("R5", "held nmi pushed status", stk[8'hF7], 8'h20);
      go(5, len);
      chk("R12", "latch cleared", len, 0);
      chk("R12", "pc after cleared latch", pc, 16'h1234);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule